// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial receive bit stream into a stream of frame bytes. Bits arrive on `bit_in` and are taken only in cycles where `bit_en` is high. The block finds the flags that bound each frame and strips the zeros that the sender inserted for transparency. It tracks the 16-bit or 32-bit frame check sequence, selected by `fcs_wide`, and checks it against the fixed residue left by a correct frame. The FCS bytes are never passed on.

Each payload byte comes out as a one-cycle pulse on `out_valid`. The first byte of a frame carries `out_sof` and the last carries `out_eof`. The last byte also carries a status word that reports a bad FCS, a trailing part-byte, an overrun, an abort, and whether the byte count is odd. A receiver hunting for a frame start, or a line held at ones, is shown on `line_idle`. Frames too short to hold a two-byte address plus the FCS are dropped without any output.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The bit pattern 0,1,1,1,1,1,1,0 (six ones between zeros) marks a frame boundary. One such flag closes the current frame and opens the next. Flags with no bytes between them produce no output. The final byte of a frame is output with `out_eof` = 1, and the first byte with `out_sof` = 1.
- R2: A zero that follows five consecutive ones is removed before bytes are assembled. Bytes are assembled least significant bit first, so payload bytes 0xFF and 0x7E come out unchanged.
- R3: With `fcs_wide` = 0, a frame's trailing 16 bits are the ones' complement of a CRC. That CRC uses polynomial 0x1021, is preset to all ones and is sent high-order bit first. The status bit 0 is 0 when the checker residue equals 0x1D0F and 1 otherwise.
- R4: With `fcs_wide` = 1, the same check uses a 32-bit CRC with polynomial 0x04C11DB7, a preset of all ones and an expected residue of 0xC704DD7B.
- R5: The FCS bytes are never output. A frame of n payload bytes yields exactly n output bytes, in order.
- R6: If bits remain after the last whole byte when the closing flag arrives, status bit 1 is set and status bit 0 is forced to 0.
- R7: Status bit 4 is the parity of the number of whole bytes received in the frame, FCS included. Because the FCS length is even, this bit is 1 exactly when the payload byte count is odd.
- R8: If `out_ready` is low during a pulse that is not a frame's last, the remaining non-final bytes of that frame are dropped. The last byte is still output, and its status bit 2 is set.
- R9: A seventh consecutive one inside a frame aborts it. If bytes of that frame were already output, one more byte is output with `out_eof` and status 0b?1000, where bit 3 is set, bits 2..0 follow R8, and bit 4 follows R7. If no bytes were output, nothing is output. All bits after an abort are ignored until the next flag.
- R10: A frame with fewer than 2 plus the FCS length in whole bytes produces no output at all.
- R11: `line_idle` rises once 15 consecutive ones have been taken and falls on the next zero.
- R12: After reset no output is valid. `out_valid` is a one-cycle pulse in the cycle after a `bit_en` cycle, and `out_stat` is zero on every pulse except the last of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial receive data |
| fcs_wide | input | 1 | 0 selects the 16-bit FCS, 1 selects the 32-bit FCS |
| out_ready | input | 1 | Downstream accepts the byte pulsed this cycle |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | One-cycle byte strobe |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame; `out_stat` valid |
| out_stat | output | 5 | {odd, abort, overrun, misaligned, fcs_bad} |
| line_idle | output | 1 | At least 15 consecutive ones seen |

## Verification
The assertions assume three things about the inputs. `bit_en` is never high in two consecutive cycles. `fcs_wide` changes only while a flag or idle ones are on the line. Downstream sees each pulse in the cycle it occurs. The bench therefore drives one bit every other cycle and switches the FCS width only between frames. It builds every bit stream with correct zero insertion, so the only stuffing faults are the aborts and long runs of ones it places on purpose.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int CNT_W     = 12,
  parameter int IDLE_ONES = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  input  logic       fcs_wide,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic [4:0] out_stat,
  output logic       line_idle
);
  localparam int OW = $clog2(IDLE_ONES + 1);

  logic [OW-1:0]      ones;
  logic [5:0]         dl;
  logic [2:0]         dl_cnt;
  logic               in_frame, ovr;
  logic [6:0]         sh;
  logic [2:0]         bcnt;
  logic [CNT_W-1:0]   cnt;
  logic [15:0]        c16;
  logic [31:0]        c32;
  logic [7:0][7:0]    hist;

  wire [2:0]       fl        = fcs_wide ? 3'd4 : 3'd2;
  wire [CNT_W-1:0] min_len   = CNT_W'(fl) + CNT_W'(2);
  wire             run6      = (ones == OW'(6));
  wire             take      = bit_en && (ones < OW'(5));
  wire             flag_ev   = bit_en && !bit_in && run6;
  wire             abort_ev  = bit_en && bit_in && run6;
  wire             db        = dl[5];
  wire             dv        = take && (dl_cnt == 3'd6) && in_frame;
  wire             byte_done = dv && (bcnt == 3'd7);
  wire [7:0]       nb        = {db, sh};
  wire [CNT_W-1:0] cnt_inc   = (&cnt) ? cnt : cnt + 1'b1;
  wire             emit      = byte_done && (cnt_inc >= min_len) && !ovr;
  wire             long_enuf = (cnt >= min_len);
  wire             close_ev  = flag_ev && in_frame && long_enuf;
  wire             kill_ev   = abort_ev && in_frame && long_enuf;
  wire             aligned   = (bcnt == 3'd0);
  wire             crc_ok    = fcs_wide ? (c32 == 32'hC704DD7B) : (c16 == 16'h1D0F);
  wire [15:0]      c16_n     = {c16[14:0], 1'b0} ^ ((c16[15] ^ db) ? 16'h1021 : 16'h0000);
  wire [31:0]      c32_n     = {c32[30:0], 1'b0} ^ ((c32[31] ^ db) ? 32'h04C11DB7 : 32'h0);

  assign line_idle = (ones == OW'(IDLE_ONES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0; dl <= '0; dl_cnt <= '0; in_frame <= 1'b0; ovr <= 1'b0;
      sh <= '0; bcnt <= '0; cnt <= '0; c16 <= '1; c32 <= '1; hist <= '0;
      out_data <= '0; out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0; out_stat <= '0;
    end else begin
      if (bit_en)
        ones <= !bit_in ? '0 : (line_idle ? ones : ones + 1'b1);
      if (take) begin
        dl <= {dl[4:0], bit_in};
        if (dl_cnt != 3'd6) dl_cnt <= dl_cnt + 1'b1;
      end
      if (dv) begin
        sh   <= nb[7:1];
        bcnt <= bcnt + 1'b1;
        c16  <= c16_n;
        c32  <= c32_n;
      end
      if (byte_done) begin
        cnt  <= cnt_inc;
        hist <= {hist[6:0], nb};
      end
      if (out_valid && !out_ready && !out_eof) ovr <= 1'b1;
      if (flag_ev) begin
        in_frame <= 1'b1; dl_cnt <= '0; bcnt <= '0; cnt <= '0;
        c16 <= '1; c32 <= '1; ovr <= 1'b0;
      end else if (abort_ev) begin
        in_frame <= 1'b0; dl_cnt <= '0;
      end
      out_valid <= emit || close_ev || kill_ev;
      out_sof   <= emit && (cnt_inc == min_len);
      out_eof   <= close_ev || kill_ev;
      if (emit || close_ev || kill_ev) out_data <= hist[fl];
      out_stat  <= close_ev ? {cnt[0], 1'b0, ovr, !aligned, aligned && !crc_ok} :
                   kill_ev  ? {cnt[0], 1'b1, ovr, 2'b00} : 5'b0;
    end
  end

  AST_EOF_IS_VALID:    assert property (@(posedge clk) disable iff (!rst_n) out_eof |-> out_valid); // R1
  AST_SOF_NOT_EOF:     assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_sof && out_eof)); // R5
  AST_PULSE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(bit_en)); // R12
  AST_STAT_ONLY_LAST:  assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_eof) |-> (out_stat == 5'b0)); // R12
  AST_OVR_SILENCES:    assert property (@(posedge clk) disable iff (!rst_n) (ovr && out_valid) |-> out_eof); // R8
  AST_ABORT_CLEAN:     assert property (@(posedge clk) disable iff (!rst_n) (out_eof && out_stat[3]) |-> (out_stat[1:0] == 2'b00)); // R9
  AST_IDLE_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) line_idle |-> !out_valid); // R11
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
module hdlc_rx_deframer_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic fcs_wide = 1'b0, out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_valid, out_sof, out_eof, line_idle;
  logic [4:0] out_stat;

  always #(CLK_P/2) clk = ~clk;

  hdlc_rx_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .fcs_wide(fcs_wide),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof),
    .out_eof(out_eof), .out_stat(out_stat), .line_idle(line_idle));

  int n_chk = 0, n_bad = 0;

  logic [7:0] cap_d [0:255];
  logic       cap_s [0:255];
  logic       cap_e [0:255];
  logic [4:0] cap_st[0:255];
  int mon_n = 0, dbl = 0;
  logic prev_v = 1'b0;

  always @(negedge clk) begin
    if (out_valid && mon_n < 256) begin
      cap_d[mon_n] <= out_data; cap_s[mon_n] <= out_sof;
      cap_e[mon_n] <= out_eof;  cap_st[mon_n] <= out_stat;
      mon_n <= mon_n + 1;
    end
    if (out_valid && prev_v) dbl <= dbl + 1;
    prev_v <= out_valid;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [7:0] fr [0:31];
  int tx_ones = 0;

  task automatic raw(input logic b);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic sbit(input logic b);
    raw(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin raw(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic flag();
    raw(1'b0);
    for (int i = 0; i < 6; i++) raw(1'b1);
    raw(1'b0);
    tx_ones = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] fcs_calc(input int n, input bit wide);
    logic [31:0] c;
    logic f;
    c = '1;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) begin
        if (wide) begin
          f = c[31] ^ fr[i][j];
          c = {c[30:0], 1'b0};
          if (f) c = c ^ 32'h04C11DB7;
        end else begin
          f = c[15] ^ fr[i][j];
          c[15:0] = {c[14:0], 1'b0};
          if (f) c[15:0] = c[15:0] ^ 16'h1021;
        end
      end
    return c;
  endfunction

  task automatic send_bytes(input int n);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 8; j++) sbit(fr[i][j]);
  endtask

  task automatic send_body(input int n, input bit wide, input bit corrupt, input int extra);
    logic [31:0] c;
    c = fcs_calc(n, wide);
    if (corrupt) fr[0] = fr[0] ^ 8'h01;
    send_bytes(n);
    for (int j = (wide ? 31 : 15); j >= 0; j--) sbit(~c[j]);
    for (int j = 0; j < extra; j++) sbit(j[0] ? 1'b0 : 1'b1);
    flag();
  endtask

  task automatic expect_frame(input int base, input int n, input logic [4:0] st, input string lab);
    int got;
    got = mon_n - base;
    if (n < 2) begin
      chk(got == 0, "R10", "short frame output count", got, 0);
      return;
    end
    chk(got == n, "R5", "output byte count", got, n);
    if (got != n) return;
    for (int i = 0; i < n; i++) begin
      chk(cap_d[base+i] == fr[i], lab, "payload byte", cap_d[base+i], fr[i]);
      chk(cap_s[base+i] == (i == 0) && cap_e[base+i] == (i == n-1), "R1",
          "sof/eof marks", {cap_s[base+i], cap_e[base+i]}, {(i == 0), (i == n-1)});
    end
    chk(cap_st[base+n-1] == st, lab, "end status R7", cap_st[base+n-1], st);
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && line_idle == 1'b0, "R12", "reset outputs", {out_valid, line_idle}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    flag();

    for (int w = 0; w < 2; w++) begin
      fcs_wide = w[0];
      for (int n = 0; n < 10; n++) begin
        for (int i = 0; i < n; i++) fr[i] = 8'((i * 29 + n * 7 + w * 90 + 3) & 8'hFF);
        base = mon_n;
        send_body(n, w[0], 1'b0, 0);
        settle();
        expect_frame(base, n, {n[0], 4'b0000}, w ? "R4" : "R3");
      end
      for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
      base = mon_n; send_body(6, w[0], 1'b0, 0); settle();
      expect_frame(base, 6, 5'h00, "R2");
      for (int i = 0; i < 7; i++) fr[i] = i[0] ? 8'h7E : 8'h3F;
      base = mon_n; send_body(7, w[0], 1'b0, 0); settle();
      expect_frame(base, 7, 5'h10, "R2");
      for (int i = 0; i < 5; i++) fr[i] = 8'(8'h40 + i);
      base = mon_n; send_body(5, w[0], 1'b1, 0); settle();
      expect_frame(base, 5, 5'h11, w ? "R4" : "R3");
      for (int i = 0; i < 4; i++) fr[i] = 8'(8'hA0 + i);
      base = mon_n; send_body(4, w[0], 1'b0, w ? 5 : 3); settle();
      expect_frame(base, 4, 5'h02, "R6");
    end

    fcs_wide = 1'b0;
    base = mon_n;
    flag(); flag();
    settle();
    chk(mon_n == base, "R1", "empty flags output count", mon_n - base, 0);

    for (int i = 0; i < 5; i++) fr[i] = 8'(8'h11 * (i + 1));
    out_ready = 1'b0;
    base = mon_n; send_body(5, 1'b0, 1'b0, 0); settle();
    out_ready = 1'b1;
    chk(mon_n - base == 2, "R8", "overrun output count", mon_n - base, 2);
    if (mon_n - base == 2) begin
      chk(cap_d[base] == fr[0] && cap_s[base] && !cap_e[base], "R8", "first byte before overrun", cap_d[base], fr[0]);
      chk(cap_d[base+1] == fr[4] && cap_e[base+1], "R8", "last byte after overrun", cap_d[base+1], fr[4]);
      chk(cap_st[base+1] == 5'h14, "R8", "overrun status", cap_st[base+1], 5'h14);
    end

    for (int i = 0; i < 5; i++) fr[i] = 8'(8'h21 + i);
    fr[5] = 8'h00;
    base = mon_n;
    send_bytes(6);
    for (int i = 0; i < 9; i++) raw(1'b1);
    tx_ones = 0;
    for (int i = 0; i < 4; i++) fr[i] = 8'(8'hC0 + i);
    send_body(4, 1'b0, 1'b0, 0);
    settle();
    chk(mon_n - base == 3, "R9", "abort output count", mon_n - base, 3);
    if (mon_n - base == 3) begin
      chk(cap_d[base] == 8'h21 && cap_d[base+1] == 8'h22 && cap_d[base+2] == 8'h23, "R9",
          "bytes before abort", cap_d[base+2], 8'h23);
      chk(cap_e[base+2] && cap_st[base+2] == 5'h18, "R9", "abort status", cap_st[base+2], 5'h18);
    end

    fr[0] = 8'h00;
    base = mon_n;
    send_bytes(1);
    for (int i = 0; i < 9; i++) raw(1'b1);
    tx_ones = 0;
    flag();
    settle();
    chk(mon_n == base, "R9", "short abort output count", mon_n - base, 0);

    for (int i = 0; i < 14; i++) raw(1'b1);
    chk(line_idle == 1'b0, "R11", "idle after 14 ones", line_idle, 0);
    raw(1'b1);
    chk(line_idle == 1'b1, "R11", "idle after 15 ones", line_idle, 1);
    raw(1'b0);
    chk(line_idle == 1'b0, "R11", "idle cleared by zero", line_idle, 0);
    flag();

    for (int i = 0; i < 3; i++) fr[i] = 8'(8'h5A ^ i);
    base = mon_n; send_body(3, 1'b0, 1'b0, 0); settle();
    expect_frame(base, 3, 5'h10, "R5");

    settle();
    chk(dbl == 0, "R12", "out_valid wider than one cycle", dbl, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule